// File: doc/BRIEF.md
# Eight-Stage Universal Shift Register with Shared Parallel Bus

The block holds eight bits in a chain of stages running from an A end to an H end. A two-bit mode input chooses one of four actions on each rising clock edge: keep the contents, move every bit one place toward H with a new bit entering at A, move every bit one place toward A with a new bit entering at H, or capture a full byte from the parallel bus. An active-low clear empties the register immediately, with no clock edge needed, and wins over every mode.

Parallel data travels both ways on one shared byte-wide bus. The bus is modelled as three signals: an incoming byte, an outgoing byte and a drive enable. The register drives the bus only when it is not loading and both active-low output enables are low. Bus bit 7 carries stage A and bus bit 0 carries stage H. Two dedicated outputs always show the A and H stages, whatever the enables do. Several registers can therefore be chained, or one register can be closed into a ring by feeding an end output back to the opposite serial input.

Top module: `usr_shift8`

## Requirements
- R1: With mode 2'b00 (hold), a rising clock edge leaves all eight stages unchanged, and bus_in is ignored.
- R2: With mode 2'b01, on a rising edge ser_a_in enters stage A (bus bit 7) and each other stage takes the value of its neighbour on the A side (bit i takes bit i+1).
- R3: With mode 2'b10, on a rising edge ser_h_in enters stage H (bus bit 0) and each other stage takes the value of its neighbour on the H side (bit i takes bit i-1).
- R4: With mode 2'b11, a rising edge captures bus_in into all eight stages (bus bit 7 into A, bit 0 into H), and bus_oe is low whatever the two enables are.
- R5: In modes 2'b00, 2'b01 and 2'b10, bus_oe is high exactly when oe1_n and oe2_n are both low; bus_out carries the stage contents, bit 7 = A and bit 0 = H.
- R6: When clr_n is low, all stages go to zero at once without a clock edge and stay zero across clock edges in every mode; q_a and q_h read 0.
- R7: After clr_n returns high between edges, the register stays zero until the next rising edge, where the selected mode acts normally.
- R8: q_a always equals stage A and q_h always equals stage H, independent of oe1_n and oe2_n.
- R9: Tying q_h to ser_a_in in mode 2'b01, or q_a to ser_h_in in mode 2'b10, rotates the eight bits; a 0x55 pattern becomes 0xAA on one edge and 0x55 again on the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Asynchronous active-low clear of all stages |
| mode | input | 2 | 00 hold, 01 shift toward H, 10 shift toward A, 11 parallel load |
| ser_a_in | input | 1 | Serial bit entering stage A in mode 01 |
| ser_h_in | input | 1 | Serial bit entering stage H in mode 10 |
| oe1_n | input | 1 | First active-low bus output enable |
| oe2_n | input | 1 | Second active-low bus output enable |
| bus_in | input | 8 | Byte seen on the shared bus (bit 7 = A) |
| bus_out | output | 8 | Stage contents offered to the shared bus (bit 7 = A) |
| bus_oe | output | 1 | High when the register drives the shared bus |
| q_a | output | 1 | Stage A, always driven |
| q_h | output | 1 | Stage H, always driven |

## Verification
The shifts are tried with alternating serial streams that fill the register from each end, so a reversed bit order shows up as 0x55 against 0xAA, and with the lopsided load value 0xC3, whose shifted images 0x61 and 0xE1 tell apart a wrong entering bit from a wrong direction. Hold mode is given a conflicting bus byte of 0xFF to show that the bus is ignored. The rotate runs feed the end outputs back and expect the alternating pattern to flip on each edge. Clear is dropped mid-shift and held across a load edge with 0xFF on the bus, which separates an asynchronous clear that has priority from a late or synchronous one.

// File: rtl/usr_pkg.sv
// Package: shared mode encoding for the universal shift register.
// Assumes the two-bit mode code is decoded identically by every stage.
package usr_pkg;
    typedef enum logic [1:0] {
        USR_HOLD = 2'b00,
        USR_TO_H = 2'b01,
        USR_TO_A = 2'b10,
        USR_LOAD = 2'b11
    } usr_mode_e;
endpackage

// File: rtl/usr_cell.sv
// Module: next-value selector for one register stage.
// Picks between keeping the stage, taking the neighbour on the A side,
// taking the neighbour on the H side, or taking the parallel bit.
// Assumes the caller supplies the serial inputs in place of missing neighbours.
module usr_cell
    import usr_pkg::*;
(
    input  usr_mode_e mode,
    input  logic      cur,
    input  logic      from_a_side,
    input  logic      from_h_side,
    input  logic      par_bit,
    output logic      nxt
);
    // Select the stage's next value from the mode code.
    always_comb begin
        unique case (mode)
            USR_HOLD: nxt = cur;
            USR_TO_H: nxt = from_a_side;
            USR_TO_A: nxt = from_h_side;
            USR_LOAD: nxt = par_bit;
            default:  nxt = cur;
        endcase
    end
endmodule

// File: rtl/usr_bus_gate.sv
// Module: drive-enable decision for the shared parallel bus.
// The register drives only outside load mode and only with both
// active-low enables low. Assumes the pad logic turns bus_oe into tri-state.
module usr_bus_gate
    import usr_pkg::*;
(
    input  usr_mode_e mode,
    input  logic      oe1_n,
    input  logic      oe2_n,
    output logic      drive
);
    logic enables_on;
    logic not_loading;

    // Combine both enables; either one high blocks the drive.
    always_comb enables_on = ~(oe1_n | oe2_n);

    // The bus turns around to an input while loading.
    always_comb not_loading = (mode != USR_LOAD);

    // Final drive decision.
    always_comb drive = enables_on & not_loading;
endmodule

// File: rtl/usr_shift8.sv
// Module: universal shift register with a shared parallel bus.
// Stage A is the top bit, stage H bit 0. The clear is asynchronous and
// active low; it is the block's functional clear and its only reset.
// Assumes clk is free-running and clr_n is released away from clock edges.
module usr_shift8
    import usr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic [1:0]       mode,
    input  logic             ser_a_in,
    input  logic             ser_h_in,
    input  logic             oe1_n,
    input  logic             oe2_n,
    input  logic [WIDTH-1:0] bus_in,
    output logic [WIDTH-1:0] bus_out,
    output logic             bus_oe,
    output logic             q_a,
    output logic             q_h
);
    localparam int TOP = WIDTH - 1;

    usr_mode_e        mode_e;
    logic [WIDTH-1:0] stages;
    logic [WIDTH-1:0] stages_nxt;

    // Interpret the raw mode pins as the shared encoding.
    always_comb mode_e = usr_mode_e'(mode);

    // One selector per stage; the end stages take the serial inputs.
    for (genvar i = 0; i < WIDTH; i++) begin : g_stage
        logic a_side;
        logic h_side;
        if (i == TOP) begin : g_a_end
            always_comb a_side = ser_a_in;
        end else begin : g_a_mid
            always_comb a_side = stages[i+1];
        end
        if (i == 0) begin : g_h_end
            always_comb h_side = ser_h_in;
        end else begin : g_h_mid
            always_comb h_side = stages[i-1];
        end
        usr_cell u_cell (
            .mode        (mode_e),
            .cur         (stages[i]),
            .from_a_side (a_side),
            .from_h_side (h_side),
            .par_bit     (bus_in[i]),
            .nxt         (stages_nxt[i])
        );
    end

    // Stage register with asynchronous clear taking priority over all modes.
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) stages <= '0;
        else        stages <= stages_nxt;
    end

    // Bus drive decision.
    usr_bus_gate u_gate (
        .mode  (mode_e),
        .oe1_n (oe1_n),
        .oe2_n (oe2_n),
        .drive (bus_oe)
    );

    // Contents toward the bus and the always-live end outputs.
    always_comb begin
        bus_out = stages;
        q_a     = stages[TOP];
        q_h     = stages[0];
    end
endmodule

// File: rtl/usr_shift8_chk.sv
// Module: property checker for usr_shift8, attached with bind.
// Observes ports only; the contents are read through bus_out.
module usr_shift8_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             clr_n,
    input logic [1:0]       mode,
    input logic             ser_a_in,
    input logic             ser_h_in,
    input logic             oe1_n,
    input logic             oe2_n,
    input logic [WIDTH-1:0] bus_in,
    input logic [WIDTH-1:0] bus_out,
    input logic             bus_oe,
    input logic             q_a,
    input logic             q_h
);
    assert_hold_R1: assert property (@(posedge clk) disable iff (!clr_n)
        (mode == 2'b00) |=> (bus_out == $past(bus_out)));

    assert_to_h_R2: assert property (@(posedge clk) disable iff (!clr_n)
        (mode == 2'b01) |=> (bus_out == {$past(ser_a_in), $past(bus_out[WIDTH-1:1])}));

    assert_to_a_R3: assert property (@(posedge clk) disable iff (!clr_n)
        (mode == 2'b10) |=> (bus_out == {$past(bus_out[WIDTH-2:0]), $past(ser_h_in)}));

    assert_load_R4: assert property (@(posedge clk) disable iff (!clr_n)
        (mode == 2'b11) |=> (bus_out == $past(bus_in)));

    assert_load_no_drive_R4: assert property (@(posedge clk) disable iff (!clr_n)
        (mode == 2'b11) |-> !bus_oe);

    assert_enable_block_R5: assert property (@(posedge clk) disable iff (!clr_n)
        (oe1_n || oe2_n) |-> !bus_oe);

    assert_clear_zero_R6: assert property (@(posedge clk)
        !clr_n |-> (bus_out == '0 && !q_a && !q_h));

    assert_ends_follow_R8: assert property (@(posedge clk) disable iff (!clr_n)
        (mode == 2'b01) |=> (q_a == $past(ser_a_in) && q_h == $past(bus_out[1])));
endmodule

bind usr_shift8 usr_shift8_chk #(.WIDTH(WIDTH)) u_chk (
    .clk      (clk),
    .clr_n    (clr_n),
    .mode     (mode),
    .ser_a_in (ser_a_in),
    .ser_h_in (ser_h_in),
    .oe1_n    (oe1_n),
    .oe2_n    (oe2_n),
    .bus_in   (bus_in),
    .bus_out  (bus_out),
    .bus_oe   (bus_oe),
    .q_a      (q_a),
    .q_h      (q_h)
);

// File: tb/sim_usr_shift8.sv
module sim_usr_shift8;
    logic       clk;
    logic       clr_n;
    logic [1:0] mode;
    logic       ser_a_in;
    logic       ser_h_in;
    logic       oe1_n;
    logic       oe2_n;
    logic [7:0] bus_in;
    logic [7:0] bus_out;
    logic       bus_oe;
    logic       q_a;
    logic       q_h;

    int n_checks = 0;
    int n_fails  = 0;

    usr_shift8 #(.WIDTH(8)) u0 (
        .clk(clk), .clr_n(clr_n), .mode(mode), .ser_a_in(ser_a_in),
        .ser_h_in(ser_h_in), .oe1_n(oe1_n), .oe2_n(oe2_n), .bus_in(bus_in),
        .bus_out(bus_out), .bus_oe(bus_oe), .q_a(q_a), .q_h(q_h)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    // Vector fields: [19:18] mode, [17] ser_a_in, [16] ser_h_in,
    // [15:8] bus_in, [7:0] expected contents after the edge.
    localparam logic [19:0] VEC [12] = '{
        {2'b11, 1'b0, 1'b0, 8'h55, 8'h55},  // R4 load
        {2'b01, 1'b1, 1'b0, 8'h00, 8'hAA},  // R2
        {2'b01, 1'b0, 1'b0, 8'h00, 8'h55},  // R2
        {2'b10, 1'b0, 1'b1, 8'h00, 8'hAB},  // R3
        {2'b10, 1'b0, 1'b0, 8'h00, 8'h56},  // R3
        {2'b00, 1'b0, 1'b0, 8'h00, 8'h56},  // R1
        {2'b11, 1'b0, 1'b0, 8'hC3, 8'hC3},  // R4
        {2'b01, 1'b0, 1'b0, 8'h00, 8'h61},  // R2
        {2'b10, 1'b0, 1'b1, 8'h00, 8'hC3},  // R3
        {2'b00, 1'b1, 1'b1, 8'hFF, 8'hC3},  // R1 bus ignored
        {2'b01, 1'b1, 1'b0, 8'h00, 8'hE1},  // R2
        {2'b10, 1'b0, 1'b0, 8'h00, 8'hC2}   // R3
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    endtask

    // Apply one edge and settle 2 ns past it.
    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    initial begin
        #1000000;
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        clr_n = 1'b0; mode = 2'b00; ser_a_in = 1'b0; ser_h_in = 1'b0;
        oe1_n = 1'b0; oe2_n = 1'b0; bus_in = 8'hFF;
        tick();
        tick();
        // R6: reset state
        check("R6 reset contents", bus_out, 8'h00);
        check("R6 reset ends", {6'd0, q_a, q_h}, 8'h00);
        clr_n = 1'b1;

        // Table walk: R1..R5, R8
        for (int i = 0; i < 12; i++) begin
            mode = VEC[i][19:18]; ser_a_in = VEC[i][17]; ser_h_in = VEC[i][16];
            bus_in = VEC[i][15:8];
            tick();
            check($sformatf("R1-4 vec%0d contents", i), bus_out, VEC[i][7:0]);
            check($sformatf("R8 vec%0d ends", i), {6'd0, q_a, q_h},
                  {6'd0, VEC[i][7], VEC[i][0]});
            check($sformatf("R5 vec%0d oe", i), {7'd0, bus_oe},
                  {7'd0, VEC[i][19:18] != 2'b11});
        end

        // R2: serial fill from the A side with 0,1,0,1,...
        mode = 2'b01;
        for (int k = 0; k < 8; k++) begin
            ser_a_in = k[0];
            tick();
        end
        check("R2 fill from A", bus_out, 8'hAA);

        // R3: serial fill from the H side with 0,1,0,1,...
        mode = 2'b10;
        for (int k = 0; k < 8; k++) begin
            ser_h_in = k[0];
            tick();
        end
        check("R3 fill from H", bus_out, 8'h55);

        // R5 / R8: enable combinations in hold mode
        mode = 2'b00;
        for (int e = 0; e < 4; e++) begin
            oe1_n = e[0]; oe2_n = e[1];
            #1;
            check($sformatf("R5 enables %0d", e), {7'd0, bus_oe}, {7'd0, e == 0});
            check($sformatf("R8 ends enables %0d", e), {6'd0, q_a, q_h}, 8'h01);
        end
        // R4: load mode never drives even with both enables low
        oe1_n = 1'b0; oe2_n = 1'b0; mode = 2'b11; bus_in = 8'h55;
        #1;
        check("R4 no drive in load", {7'd0, bus_oe}, 8'h00);
        tick();
        check("R4 load", bus_out, 8'h55);

        // R9: rotate toward H with q_h fed to ser_a_in
        mode = 2'b01;
        ser_a_in = q_h; tick();
        check("R9 rotate toward H 1", bus_out, 8'hAA);
        ser_a_in = q_h; tick();
        check("R9 rotate toward H 2", bus_out, 8'h55);
        // R9: rotate toward A with q_a fed to ser_h_in
        mode = 2'b10;
        ser_h_in = q_a; tick();
        check("R9 rotate toward A 1", bus_out, 8'hAA);
        ser_h_in = q_a; tick();
        check("R9 rotate toward A 2", bus_out, 8'h55);

        // R6: clear mid-shift, no edge needed
        mode = 2'b01; ser_a_in = 1'b1;
        tick();
        check("R6 before clear", bus_out, 8'hAA);
        clr_n = 1'b0;
        #1;
        check("R6 async clear", bus_out, 8'h00);
        // R6: clear wins over a load edge
        mode = 2'b11; bus_in = 8'hFF;
        tick();
        check("R6 clear over load", bus_out, 8'h00);
        check("R6 ends cleared", {6'd0, q_a, q_h}, 8'h00);
        // R7: release between edges, nothing until next edge
        #2;
        clr_n = 1'b1;
        #1;
        check("R7 zero after release", bus_out, 8'h00);
        tick();
        check("R7 load after release", bus_out, 8'hFF);

        summary();
    end
endmodule